// File: doc/BRIEF.md
# Flash Address Capture Front End

This block sits between the external address pins of a NOR-style flash memory model and its internal read and write paths. It decides when the internal address follows the external bus and when it is frozen. The decision depends on the address-valid strobe, the chip-enable and write-enable strobes, a free-running flash clock, and two configuration inputs. One selects synchronous (clocked) or asynchronous read behaviour. The other says whether the address-valid strobe is permanently tied low on the board.

All strobes and the flash clock are taken as levels that are already synchronous to the model's system clock `clk`. Edges are found by comparing each sample with the one from the previous cycle. The internal address is a register that loads the bus in the same cycle as the event that loads it. It is therefore visible one `clk` cycle after the bus value it holds.

Top module: `flash_addr_capture`

## Requirements
- R1: After a synchronous active-low reset, `int_addr` is 0 and the latch is armed, so `latch_open` is 1 as soon as `adv_n` is seen low in the non-tied configuration.
- R2: With `adv_tied`=0, in every cycle where `adv_n` is low and the latch is armed, `int_addr` takes the `bus_addr` of that cycle on the next `clk` edge.
- R3: With `adv_tied`=0, in every cycle where `adv_n` is high, `int_addr` keeps its value and `bus_addr` has no effect. A high `adv_n` re-arms the latch for the next low period.
- R4: With `adv_tied`=0, `sync_mode`=1 and `we_n`=1, the first active flash clock edge seen while `adv_n` is low and the latch is armed loads that cycle's bus and closes the latch. Later bus changes are ignored until `adv_n` has been high for at least one cycle and goes low again.
- R5: The active flash clock edge is a 0-to-1 change between two samples of `fclk` when parameter `FCLK_RISE`=1 (the default), and a 1-to-0 change when it is 0.
- R6: While `we_n` is low (a write), the flash clock is ignored. The latch stays transparent until `adv_n` rises, and the write address is the last bus value seen with `adv_n` low.
- R7: With `sync_mode`=0 the flash clock never closes the latch. `int_addr` follows the bus for the whole `adv_n` low period.
- R8: With `adv_tied`=1, `adv_n` has no effect. A read address is loaded from the bus in the cycle where `ce_n` is first seen high after being low.
- R9: With `adv_tied`=1, in a write (`ce_n` and `we_n` both low), the first of a `ce_n` or `we_n` rise loads the bus. A later rise of the other strobe within the same access is ignored. A new access starts when `ce_n` falls.
- R10: `latch_open` is 1 exactly when `adv_tied`=0, `adv_n` is low and the latch has not been closed by the flash clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of the model |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | External address bus |
| adv_n | input | 1 | Address-valid strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| fclk | input | 1 | Flash clock, sampled as a level |
| sync_mode | input | 1 | 1: synchronous read, flash clock closes the latch; 0: asynchronous |
| adv_tied | input | 1 | Static: 1 when the address-valid strobe is wired low permanently |
| int_addr | output | ADDR_W | Captured internal address |
| latch_open | output | 1 | 1 while the bus passes through to `int_addr` |

## Verification
The assertions assume that `adv_tied` and `sync_mode` change only while reset is held, and that strobes and `fclk` are stable across each `clk` edge. The bench drives every input on the falling edge of `clk` and changes the two configuration inputs only inside a reset sequence. The random phases toggle each strobe with its own probability and toggle `fclk` every second cycle on average. Writes with a clock edge while the strobe is low, and accesses where either strobe rises first, therefore occur many times in each configuration.

// File: rtl/flash_alc_pkg.sv
// Package: shared types for the flash address capture front end.
// Assumes nothing beyond being compiled before the modules that import it.
package flash_alc_pkg;

    // Strobe edge events found by comparing the current sample with the previous one.
    typedef struct packed {
        logic ce_rise;
        logic ce_fall;
        logic we_rise;
        logic fclk_edge;
        logic ce_n_q;
    } falc_edges_t;

    // Which path loads the internal address register in this cycle.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_ADV    = 2'd1,
        SRC_STROBE = 2'd2
    } falc_src_t;

endpackage

// File: rtl/falc_edge_detect.sv
// Edge detector: registers the previous level of ce_n, we_n and fclk and
// reports rising/falling events. FCLK_RISE picks the active flash clock edge.
// Assumes inputs are synchronous to clk. Reset values are the idle levels.
module falc_edge_detect
    import flash_alc_pkg::*;
#(
    parameter bit FCLK_RISE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        fclk,
    output falc_edges_t edges
);

    logic ce_n_q;
    logic we_n_q;
    logic fclk_q;
    logic fclk_hit;

    // Purpose: remember last cycle's strobe levels (idle after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            we_n_q <= 1'b1;
            fclk_q <= 1'b0;
        end else begin
            ce_n_q <= ce_n;
            we_n_q <= we_n;
            fclk_q <= fclk;
        end
    end

    // Purpose: pick the active flash clock edge at elaboration time.
    generate
        if (FCLK_RISE) begin : g_rise
            assign fclk_hit = fclk & ~fclk_q;
        end else begin : g_fall
            assign fclk_hit = ~fclk & fclk_q;
        end
    endgenerate

    // Purpose: pack the events for the control paths.
    always_comb begin
        edges.ce_rise   = ce_n & ~ce_n_q;
        edges.ce_fall   = ~ce_n & ce_n_q;
        edges.we_rise   = we_n & ~we_n_q;
        edges.fclk_edge = fclk_hit;
        edges.ce_n_q    = ce_n_q;
    end

endmodule

// File: rtl/falc_adv_ctrl.sv
// Address-valid path: the latch is transparent while adv_n is low and armed.
// In synchronous read mode the first active flash clock edge with adv_n low
// closes it until adv_n goes high again. Writes ignore the flash clock.
// Assumes sync_mode changes only during reset.
module falc_adv_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic adv_n,
    input  logic we_n,
    input  logic sync_mode,
    input  logic fclk_edge,
    output logic load,
    output logic open_now
);

    logic armed_q;
    logic clk_close;

    // Purpose: decide loading and the synchronous close event.
    always_comb begin
        open_now  = enable & ~adv_n & armed_q;
        load      = open_now;
        clk_close = open_now & sync_mode & we_n & fclk_edge;
    end

    // Purpose: armed flag, set by adv_n high, cleared by a clock close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (adv_n) begin
            armed_q <= 1'b1;
        end else if (clk_close) begin
            armed_q <= 1'b0;
        end
    end

    // R4: a clock edge during a synchronous read closes the latch.
    a_r4_clock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync_mode && we_n && !adv_n && armed_q && fclk_edge) |=> !armed_q);

    // R6: a write keeps the latch armed whatever the flash clock does.
    a_r6_write_ignores_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && armed_q) |=> armed_q);

    // R7: asynchronous mode never closes the latch.
    a_r7_async_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && armed_q) |=> armed_q);

endmodule

// File: rtl/falc_tied_ctrl.sv
// Strobe path for boards with the address-valid strobe tied low: loads on
// ce_n rising, or on we_n rising while selected, whichever comes first
// within one access. A falling ce_n starts a new access.
// Assumes adv_tied (enable) changes only during reset.
module falc_tied_ctrl
    import flash_alc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  falc_edges_t edges,
    output logic        load
);

    logic done_q;
    logic trigger;

    // Purpose: first qualifying strobe rise of the current access.
    always_comb begin
        trigger = edges.ce_rise | (edges.we_rise & ~edges.ce_n_q);
        load    = enable & ~done_q & trigger;
    end

    // Purpose: remember that this access already captured its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (edges.ce_fall) begin
            done_q <= 1'b0;
        end else if (load) begin
            done_q <= 1'b1;
        end
    end

    // R9: once captured, the access stays captured until ce_n falls.
    a_r9_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !edges.ce_fall) |=> done_q);

endmodule

// File: rtl/flash_addr_capture.sv
// Top: the internal address register of the flash model, loaded either by
// the address-valid path or, when that strobe is tied low, by the strobe
// path. Assumes all inputs are synchronous to clk and that adv_tied and
// sync_mode are static outside reset.
module flash_addr_capture
    import flash_alc_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter bit FCLK_RISE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              fclk,
    input  logic              sync_mode,
    input  logic              adv_tied,
    output logic [ADDR_W-1:0] int_addr,
    output logic              latch_open
);

    localparam logic [ADDR_W-1:0] ADDR_RESET = '0;

    falc_edges_t       edges;
    logic              adv_load;
    logic              tied_load;
    falc_src_t         src;
    logic [ADDR_W-1:0] addr_q;

    falc_edge_detect #(
        .FCLK_RISE (FCLK_RISE)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .fclk  (fclk),
        .edges (edges)
    );

    falc_adv_ctrl u_adv (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (~adv_tied),
        .adv_n     (adv_n),
        .we_n      (we_n),
        .sync_mode (sync_mode),
        .fclk_edge (edges.fclk_edge),
        .load      (adv_load),
        .open_now  (latch_open)
    );

    falc_tied_ctrl u_tied (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (adv_tied),
        .edges  (edges),
        .load   (tied_load)
    );

    // Purpose: select the loading path for this cycle.
    always_comb begin
        src = SRC_HOLD;
        if (adv_tied) begin
            if (tied_load) src = SRC_STROBE;
        end else if (adv_load) begin
            src = SRC_ADV;
        end
    end

    // Purpose: internal address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= ADDR_RESET;
        end else if (src != SRC_HOLD) begin
            addr_q <= bus_addr;
        end
    end

    assign int_addr = addr_q;

    // R2: an open latch passes the bus to the internal address.
    a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_tied && latch_open) |=> (int_addr == $past(bus_addr)));

    // R3: a high address-valid strobe freezes the internal address.
    a_r3_hold_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_tied && adv_n) |=> (int_addr == $past(int_addr)));

    // R9: with both strobes low no edge can load in the tied configuration.
    a_r9_hold_mid_write: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_tied && !ce_n && !we_n) |=> (int_addr == $past(int_addr)));

    // R10: the open flag never shows in the tied configuration.
    a_r10_open_only_untied: assert property (@(posedge clk) disable iff (!rst_n)
        adv_tied |-> !latch_open);

endmodule

// File: tb/flash_addr_capture_bench.sv
module flash_addr_capture_bench;

    localparam int ADDR_W = 23;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              adv_n = 1'b1;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              fclk = 1'b0;
    logic              sync_mode = 1'b0;
    logic              adv_tied = 1'b0;
    logic [ADDR_W-1:0] int_addr;
    logic              latch_open;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference state
    logic [ADDR_W-1:0] m_addr;
    bit m_armed, m_done, p_ce, p_we, p_fclk;

    always #5 clk = ~clk;

    flash_addr_capture #(.ADDR_W(ADDR_W)) u_flash_addr_capture (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .adv_n(adv_n),
        .ce_n(ce_n), .we_n(we_n), .fclk(fclk), .sync_mode(sync_mode),
        .adv_tied(adv_tied), .int_addr(int_addr), .latch_open(latch_open)
    );

    task automatic chk_addr(input string req, input logic [ADDR_W-1:0] act,
                            input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: int_addr=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: latch_open=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit open_expected();
        return !adv_tied && !adv_n && m_armed;
    endfunction

    // Reference update at a clk edge, from the requirement text (R2-R9).
    task automatic model_edge();
        bit cer, wer, cef, close;
        if (!adv_tied) begin
            close = sync_mode && we_n && !adv_n && m_armed && fclk && !p_fclk;
            if (!adv_n && m_armed) m_addr = bus_addr;
            if (adv_n) m_armed = 1'b1;
            else if (close) m_armed = 1'b0;
        end else begin
            cer = ce_n && !p_ce;
            wer = we_n && !p_we && !p_ce;
            cef = !ce_n && p_ce;
            if (cef) m_done = 1'b0;
            else if (!m_done && (cer || wer)) begin
                m_addr = bus_addr;
                m_done = 1'b1;
            end
        end
        p_ce = ce_n; p_we = we_n; p_fclk = fclk;
    endtask

    // One cycle: drive at negedge, check the open flag, model the edge, check the address.
    task automatic step(input logic a, input logic c, input logic w, input logic f,
                        input logic [ADDR_W-1:0] b);
        @(negedge clk);
        adv_n = a; ce_n = c; we_n = w; fclk = f; bus_addr = b;
        #1;
        chk_bit("R10", latch_open, open_expected());
        @(posedge clk);
        model_edge();
        #1;
        chk_addr("R2 R3 R4 R6 R7 R8 R9 model", int_addr, m_addr);
    endtask

    task automatic do_reset(input logic tied, input logic sync);
        @(negedge clk);
        rst_n = 1'b0; adv_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; fclk = 1'b0;
        adv_tied = tied; sync_mode = sync;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_addr = '0; m_armed = 1'b1; m_done = 1'b0;
        p_ce = 1'b1; p_we = 1'b1; p_fclk = 1'b0;
        #1;
        chk_addr("R1 reset value", int_addr, '0);
    endtask

    task automatic random_phase(input logic tied, input logic sync, input int n);
        logic a, c, w, f;
        logic [ADDR_W-1:0] b;
        do_reset(tied, sync);
        a = 1'b1; c = 1'b1; w = 1'b1; f = 1'b0; b = '0;
        for (int i = 0; i < n; i++) begin
            if ($urandom % 4 == 0) a = ~a;
            if ($urandom % 5 == 0) c = ~c;
            if ($urandom % 4 == 0) w = ~w;
            if ($urandom % 2 == 0) f = ~f;
            if ($urandom % 2 == 0) b = ADDR_W'($urandom);
            step(a, c, w, f, b);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);

        // R1: reset state, armed latch opens at the first low strobe.
        do_reset(1'b0, 1'b1);
        @(negedge clk); adv_n = 1'b0; #1;
        chk_bit("R1 armed after reset", latch_open, 1'b1);

        // R2, R4, R5, R10: synchronous read closes on rising flash clock.
        step(1'b0, 1'b0, 1'b1, 1'b0, 23'h0000A1);
        chk_addr("R2 transparent", int_addr, 23'h0000A1);
        step(1'b0, 1'b0, 1'b1, 1'b1, 23'h0000A2);
        chk_addr("R4 R5 captured at clock edge", int_addr, 23'h0000A2);
        step(1'b0, 1'b0, 1'b1, 1'b0, 23'h0000A3);
        chk_addr("R4 closed ignores bus", int_addr, 23'h0000A2);
        chk_bit("R10 closed", latch_open, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b1, 23'h0000A4);
        chk_addr("R3 high strobe holds", int_addr, 23'h0000A2);
        step(1'b0, 1'b0, 1'b1, 1'b1, 23'h0000A5);
        chk_addr("R4 reopened after high", int_addr, 23'h0000A5);

        // R6: a write ignores the flash clock and follows until the strobe rises.
        step(1'b1, 1'b0, 1'b0, 1'b0, 23'h000001);
        step(1'b0, 1'b0, 1'b0, 1'b1, 23'h0000B6);
        step(1'b0, 1'b0, 1'b0, 1'b0, 23'h0000B7);
        chk_addr("R6 write stays transparent", int_addr, 23'h0000B7);
        step(1'b1, 1'b0, 1'b0, 1'b1, 23'h0000B8);
        chk_addr("R6 write address held at rise", int_addr, 23'h0000B7);

        // R7: asynchronous mode follows the bus through clock edges.
        do_reset(1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 23'h0000C1);
        step(1'b0, 1'b0, 1'b1, 1'b0, 23'h0000C2);
        step(1'b0, 1'b0, 1'b1, 1'b1, 23'h0000C3);
        chk_addr("R7 async ignores clock", int_addr, 23'h0000C3);

        // R8, R9: tied strobe configuration.
        do_reset(1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, 23'h0000D0);
        chk_bit("R10 tied never open", latch_open, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 23'h0000D1);
        chk_addr("R9 no capture mid write", int_addr, '0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 23'h0000D2);
        chk_addr("R9 write enable rose first", int_addr, 23'h0000D2);
        step(1'b1, 1'b1, 1'b1, 1'b0, 23'h0000D3);
        chk_addr("R9 later chip enable rise ignored", int_addr, 23'h0000D2);
        step(1'b1, 1'b0, 1'b1, 1'b0, 23'h0000D4);
        step(1'b0, 1'b1, 1'b1, 1'b1, 23'h0000D5);
        chk_addr("R8 read captured on chip enable rise", int_addr, 23'h0000D5);
        step(1'b1, 1'b1, 1'b1, 1'b0, 23'h0000D6);
        chk_addr("R8 strobe ignored", int_addr, 23'h0000D5);

        // Random phases across all configurations.
        random_phase(1'b0, 1'b1, 3000);
        random_phase(1'b0, 1'b0, 3000);
        random_phase(1'b1, 1'b1, 3000);
        random_phase(1'b1, 1'b0, 3000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule